// File: doc/BRIEF.md
# Aliased Set/Clear/Toggle Control Register Bank

This block is the software-visible register file of a multi-channel coprocessor. A 32-bit word bus reaches a global control register, a global status register, a channel-control register and one bank of four registers per channel: a command pointer, a semaphore, a channel status word and an options word. Every register answers at four word addresses. The base offset replaces the writable bits. Base plus 0x4 ORs the data in. Base plus 0x8 clears every bit written as one. Base plus 0xC inverts every bit written as one. Software can therefore change single bits without a read-modify-write sequence.

The channel engines sit outside this block. They report completion pulses, error codes, a ready mask and the index of the channel now running. The block drives the channel enables, the priority marks, the pointers and options, a one-cycle start pulse per channel, and a single interrupt line.

Top module: `alias_csr_bank`

## Requirements
- R1: After reset the control register reads 0x7000_0000: the clock-gate bit (30) is 1, and bits 29 and 28 are the capability flags, both 1 with default parameters. Every other register reads 0, and every output is 0 except `clock_gate`, which is 1.
- R2: Let op = address bits 3:2. Op 0 writes the data, op 1 ORs it in, op 2 clears the written-one bits, and op 3 inverts the written-one bits. Only the writable bits of the target change. The writable bits are: control 31, 30 and 3:0; status 3:0; channel-control 11:8 and 3:0; pointer and options 31:0; semaphore and channel status 7:0.
- R3: A read at any of the four aliases of a register returns that register's value. A read at an unmapped or non-word-aligned address returns 0. Mapped addresses are 0x000 (control), 0x010 (status), 0x020 (channel control), and 0x100/0x110/0x120/0x130 + n*0x40 (pointer/semaphore/status/options of channel n).
- R4: Control bits 29 and 28 always read as the capability parameters, whatever is written. Control bits 27:4 always read 0.
- R5: A completion pulse on `eng_done[n]` sets status bit n. When a completion pulse and a software clear of the same bit fall in one cycle, the bit ends up set. Status bits 19:16 show `eng_ready`, and bits 27:24 show `eng_cur`.
- R6: `irq` is high exactly when some channel has both its status flag (status bit n) and its control enable (control bit n) set.
- R7: `chan_enable[n]` follows channel-control bit n, and `chan_high_prio[n]` follows channel-control bit 8+n.
- R8: `chan_ptr` and `chan_opt` present each channel's pointer and options registers, with channel n in bits 32n+31:32n.
- R9: A write through any alias to channel n's semaphore whose result is nonzero raises `chan_kick[n]` for exactly the following cycle. A write whose result is zero does not. A completion pulse decrements a nonzero semaphore, unless a semaphore write lands in the same cycle.
- R10: An `eng_err[n]` pulse ORs `eng_err_code[8n+7:8n]` into channel n's status bits 7:0. Those bits stay set until software clears them.
- R11: While control bit 31 (soft reset) is 1, every register except the control register is held at 0, writes to those registers are ignored, engine events are ignored, and no start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address; bits 3:2 select the alias |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| eng_done | input | NCH | Per-channel completion pulses |
| eng_err | input | NCH | Per-channel error pulses |
| eng_err_code | input | 8*NCH | Error code bits per channel |
| eng_ready | input | NCH | Ready-channel mask, shown in status |
| eng_cur | input | 4 | Currently running channel, shown in status |
| soft_reset | output | 1 | Control bit 31 |
| clock_gate | output | 1 | Control bit 30 |
| chan_enable | output | NCH | Channel enables |
| chan_high_prio | output | NCH | High-priority marks |
| chan_ptr | output | 32*NCH | Command pointers |
| chan_opt | output | 32*NCH | Options words |
| chan_kick | output | NCH | One-cycle start pulses |
| irq | output | 1 | Combined interrupt |

## Verification
A long run of random writes goes to random registers through random aliases. A bench model predicts each result, and the register is then read back through a different random alias. This separates the four alias operations from one another and confirms that the alias used for a read does not change what it returns. Control writes with all data bits set show whether the read-only and unused bits are truly masked. Semaphore writes through the clear and toggle aliases show whether the start pulse follows the resulting value or only the raw data. Directed cases place a completion pulse in the same cycle as a status clear, decrement a semaphore, merge error codes, and hold soft reset while writes and events arrive. These cases tell event priority apart from plain software access.

// File: rtl/stc_csr_pkg.sv
package stc_csr_pkg;
  localparam int unsigned ADDR_W = 12;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_e;

  // Apply an aliased access; bits outside wmask keep their current value.
  function automatic logic [31:0] alias_apply(input logic [31:0] cur,
                                              input logic [31:0] data,
                                              input alias_op_e op,
                                              input logic [31:0] wmask);
    logic [31:0] nv;
    case (op)
      OP_WRITE: nv = data;
      OP_SET:   nv = cur | data;
      OP_CLR:   nv = cur & ~data;
      default:  nv = cur ^ data;
    endcase
    return (cur & ~wmask) | (nv & wmask);
  endfunction

  function automatic logic [31:0] low_ones(input int unsigned n);
    if (n >= 32) return '1;
    return (32'h1 << n) - 32'h1;
  endfunction
endpackage

// File: rtl/stc_csr_decode.sv
module stc_csr_decode
  import stc_csr_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = ADDR_W
) (
  input  logic [AW-1:0]  addr,
  output alias_op_e      op,
  output logic           hit_ctrl,
  output logic           hit_stat,
  output logic           hit_chctl,
  output logic [NCH-1:0] hit_ptr,
  output logic [NCH-1:0] hit_sema,
  output logic [NCH-1:0] hit_cst,
  output logic [NCH-1:0] hit_opt
);
  localparam logic [AW-9:0] CH_AREA = (AW-8)'(1);

  logic aligned, glob_area, chan_area;

  assign aligned   = (addr[1:0] == 2'b00);
  assign glob_area = aligned && (addr[AW-1:6] == '0);
  assign chan_area = aligned && (addr[AW-1:8] == CH_AREA);
  assign op        = alias_op_e'(addr[3:2]);

  assign hit_ctrl  = glob_area && (addr[5:4] == 2'd0);
  assign hit_stat  = glob_area && (addr[5:4] == 2'd1);
  assign hit_chctl = glob_area && (addr[5:4] == 2'd2);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic this_ch;
    assign this_ch     = chan_area && (addr[7:6] == 2'(g));
    assign hit_ptr[g]  = this_ch && (addr[5:4] == 2'd0);
    assign hit_sema[g] = this_ch && (addr[5:4] == 2'd1);
    assign hit_cst[g]  = this_ch && (addr[5:4] == 2'd2);
    assign hit_opt[g]  = this_ch && (addr[5:4] == 2'd3);
  end
endmodule

// File: rtl/stc_csr_global.sv
module stc_csr_global
  import stc_csr_pkg::*;
#(
  parameter int unsigned NCH        = 4,
  parameter bit          HAS_CIPHER = 1'b1,
  parameter bit          HAS_HASH   = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  alias_op_e      op,
  input  logic [31:0]    wdata,
  input  logic           hit_ctrl,
  input  logic           hit_stat,
  input  logic           hit_chctl,
  input  logic [NCH-1:0] ch_done,
  input  logic [NCH-1:0] ch_ready,
  input  logic [3:0]     cur_ch,
  output logic [31:0]    ctrl_rd,
  output logic [31:0]    stat_rd,
  output logic [31:0]    chctl_rd,
  output logic           srst,
  output logic           clk_gate,
  output logic [NCH-1:0] irq_en,
  output logic [NCH-1:0] flags,
  output logic [NCH-1:0] ch_enable,
  output logic [NCH-1:0] ch_prio
);
  localparam logic [31:0] EN_MASK     = low_ones(NCH);
  localparam logic [31:0] CTRL_WMASK  = 32'hC000_0000 | EN_MASK;
  localparam logic [31:0] CTRL_RST    = 32'h4000_0000;
  localparam logic [31:0] CAPS        = (HAS_CIPHER ? 32'h2000_0000 : 32'h0) |
                                        (HAS_HASH   ? 32'h1000_0000 : 32'h0);
  localparam logic [31:0] CHCTL_WMASK = EN_MASK | (EN_MASK << 8);

  logic [31:0]    ctrl_q, chctl_q, flag_wide;
  logic [NCH-1:0] flag_q;

  // Control register: never forced by soft reset, so software can release it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ctrl_q <= CTRL_RST;
    else if (wr_en && hit_ctrl)  ctrl_q <= alias_apply(ctrl_q, wdata, op, CTRL_WMASK);
  end

  assign srst = ctrl_q[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  chctl_q <= '0;
    else if (srst)               chctl_q <= '0;
    else if (wr_en && hit_chctl) chctl_q <= alias_apply(chctl_q, wdata, op, CHCTL_WMASK);
  end

  assign flag_wide = alias_apply(32'(flag_q), wdata, op, EN_MASK);

  // Engine completion has priority over a software clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag_q <= '0;
    else if (srst)              flag_q <= '0;
    else if (wr_en && hit_stat) flag_q <= flag_wide[NCH-1:0] | ch_done;
    else                        flag_q <= flag_q | ch_done;
  end

  assign ctrl_rd   = ctrl_q | CAPS;
  assign chctl_rd  = chctl_q;
  assign stat_rd   = {4'b0, cur_ch, 4'b0, 4'(ch_ready), 12'b0, 4'(flag_q)};
  assign clk_gate  = ctrl_q[30];
  assign irq_en    = ctrl_q[NCH-1:0];
  assign flags     = flag_q;
  assign ch_enable = chctl_q[NCH-1:0];
  assign ch_prio   = chctl_q[8 +: NCH];

  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(srst) |-> ((flag_q & $past(ch_done)) == $past(ch_done)));

  p_srst_global_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst) |-> (chctl_q == 32'h0 && flag_q == '0));

  p_caps_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && hit_ctrl) |-> (ctrl_rd[29:28] == {HAS_CIPHER, HAS_HASH}));
endmodule

// File: rtl/stc_csr_chan.sv
module stc_csr_chan
  import stc_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srst,
  input  logic        wr_en,
  input  alias_op_e   op,
  input  logic [31:0] wdata,
  input  logic        hit_ptr,
  input  logic        hit_sema,
  input  logic        hit_cst,
  input  logic        hit_opt,
  input  logic        done,
  input  logic        err,
  input  logic [7:0]  err_code,
  output logic [31:0] ptr_q,
  output logic [31:0] opt_q,
  output logic [7:0]  sema_q,
  output logic [7:0]  cst_q,
  output logic        kick
);
  logic [31:0] sema_next, cst_next;
  logic [7:0]  cst_d;
  logic        sema_wr, sema_start;

  assign sema_next  = alias_apply(32'(sema_q), wdata, op, 32'h0000_00FF);
  assign cst_next   = alias_apply(32'(cst_q), wdata, op, 32'h0000_00FF);
  assign sema_wr    = wr_en && hit_sema;
  assign sema_start = sema_wr && (sema_next[7:0] != 8'h00);

  always_comb begin
    cst_d = (wr_en && hit_cst) ? cst_next[7:0] : cst_q;
    if (err) cst_d = cst_d | err_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0; opt_q <= '0; sema_q <= '0; cst_q <= '0; kick <= 1'b0;
    end else if (srst) begin
      ptr_q <= '0; opt_q <= '0; sema_q <= '0; cst_q <= '0; kick <= 1'b0;
    end else begin
      if (wr_en && hit_ptr) ptr_q <= alias_apply(ptr_q, wdata, op, 32'hFFFF_FFFF);
      if (wr_en && hit_opt) opt_q <= alias_apply(opt_q, wdata, op, 32'hFFFF_FFFF);
      if (sema_wr)                       sema_q <= sema_next[7:0];
      else if (done && sema_q != 8'h00)  sema_q <= sema_q - 8'd1;
      cst_q <= cst_d;
      kick  <= sema_start;
    end
  end

  p_kick_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> $past(wr_en && hit_sema));

  p_sema_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(srst) && $past(done && !(wr_en && hit_sema) && sema_q != 8'h00))
      |-> (sema_q == $past(sema_q) - 8'd1));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err) && !$past(srst)) |-> ((cst_q & $past(err_code)) == $past(err_code)));

  p_srst_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst) |-> (ptr_q == 32'h0 && opt_q == 32'h0 && sema_q == 8'h0 &&
                     cst_q == 8'h0 && !kick));
endmodule

// File: rtl/alias_csr_bank.sv
module alias_csr_bank
  import stc_csr_pkg::*;
#(
  parameter int unsigned NCH        = 4,
  parameter bit          HAS_CIPHER = 1'b1,
  parameter bit          HAS_HASH   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NCH-1:0]       eng_done,
  input  logic [NCH-1:0]       eng_err,
  input  logic [8*NCH-1:0]     eng_err_code,
  input  logic [NCH-1:0]       eng_ready,
  input  logic [3:0]           eng_cur,
  output logic                 soft_reset,
  output logic                 clock_gate,
  output logic [NCH-1:0]       chan_enable,
  output logic [NCH-1:0]       chan_high_prio,
  output logic [32*NCH-1:0]    chan_ptr,
  output logic [32*NCH-1:0]    chan_opt,
  output logic [NCH-1:0]       chan_kick,
  output logic                 irq
);
  alias_op_e      op;
  logic           hit_ctrl, hit_stat, hit_chctl;
  logic [NCH-1:0] hit_ptr, hit_sema, hit_cst, hit_opt;
  logic [31:0]    ctrl_rd, stat_rd, chctl_rd;
  logic [NCH-1:0] irq_en, flags;
  logic [7:0]     sema_v [NCH];
  logic [7:0]     cst_v  [NCH];

  stc_csr_decode #(.NCH(NCH), .AW(ADDR_W)) u_dec (
    .addr(bus_addr), .op(op), .hit_ctrl(hit_ctrl), .hit_stat(hit_stat),
    .hit_chctl(hit_chctl), .hit_ptr(hit_ptr), .hit_sema(hit_sema),
    .hit_cst(hit_cst), .hit_opt(hit_opt)
  );

  stc_csr_global #(.NCH(NCH), .HAS_CIPHER(HAS_CIPHER), .HAS_HASH(HAS_HASH)) u_glb (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .op(op), .wdata(bus_wdata),
    .hit_ctrl(hit_ctrl), .hit_stat(hit_stat), .hit_chctl(hit_chctl),
    .ch_done(eng_done), .ch_ready(eng_ready), .cur_ch(eng_cur),
    .ctrl_rd(ctrl_rd), .stat_rd(stat_rd), .chctl_rd(chctl_rd),
    .srst(soft_reset), .clk_gate(clock_gate), .irq_en(irq_en), .flags(flags),
    .ch_enable(chan_enable), .ch_prio(chan_high_prio)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_bank
    stc_csr_chan u_ch (
      .clk(clk), .rst_n(rst_n), .srst(soft_reset), .wr_en(bus_wr), .op(op),
      .wdata(bus_wdata), .hit_ptr(hit_ptr[g]), .hit_sema(hit_sema[g]),
      .hit_cst(hit_cst[g]), .hit_opt(hit_opt[g]), .done(eng_done[g]),
      .err(eng_err[g]), .err_code(eng_err_code[8*g +: 8]),
      .ptr_q(chan_ptr[32*g +: 32]), .opt_q(chan_opt[32*g +: 32]),
      .sema_q(sema_v[g]), .cst_q(cst_v[g]), .kick(chan_kick[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)  bus_rdata = ctrl_rd;
    if (hit_stat)  bus_rdata = stat_rd;
    if (hit_chctl) bus_rdata = chctl_rd;
    for (int i = 0; i < NCH; i++) begin
      if (hit_ptr[i])  bus_rdata = chan_ptr[32*i +: 32];
      if (hit_sema[i]) bus_rdata = 32'(sema_v[i]);
      if (hit_cst[i])  bus_rdata = 32'(cst_v[i]);
      if (hit_opt[i])  bus_rdata = chan_opt[32*i +: 32];
    end
  end

  assign irq = |(flags & irq_en);

  p_one_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_ctrl, hit_stat, hit_chctl, hit_ptr, hit_sema, hit_cst, hit_opt}));

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(bus_wr) || ($past(eng_done) != '0)));
endmodule

// File: tb/sim_alias_csr_bank.sv
`timescale 1ns/1ps
module sim_alias_csr_bank;
  localparam int NCH = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [11:0]       bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NCH-1:0]    eng_done = '0, eng_err = '0, eng_ready = '0;
  logic [8*NCH-1:0]  eng_err_code = '0;
  logic [3:0]        eng_cur = '0;
  logic              soft_reset, clock_gate, irq;
  logic [NCH-1:0]    chan_enable, chan_high_prio, chan_kick;
  logic [32*NCH-1:0] chan_ptr, chan_opt;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  logic [31:0] m [19];

  always #2 clk = ~clk;

  alias_csr_bank #(.NCH(NCH)) u0 (.*);

  function automatic logic [31:0] keep_of(int idx);
    if (idx == 0) return 32'hC000_000F;
    if (idx == 1) return 32'h0000_000F;
    if (idx == 2) return 32'h0000_0F0F;
    case ((idx - 3) % 4)
      0, 3:    return 32'hFFFF_FFFF;
      default: return 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic [11:0] addr_of(int idx, int op);
    int base;
    if (idx < 3) base = idx * 16;
    else base = 256 + ((idx - 3) / 4) * 64 + ((idx - 3) % 4) * 16;
    return 12'(base + op * 4);
  endfunction

  function automatic logic [31:0] next_val(int op, logic [31:0] cur, logic [31:0] d, logic [31:0] keep);
    logic [31:0] r;
    if (op == 0)      r = d;
    else if (op == 1) r = cur | d;
    else if (op == 2) r = cur & ~d;
    else              r = cur ^ d;
    return (cur & ~keep) | (r & keep);
  endfunction

  function automatic logic [31:0] exp_read(int idx);
    if (idx == 0) return m[0] | 32'h3000_0000;
    if (idx == 1) return m[1] | (32'(eng_ready) << 16) | (32'(eng_cur) << 24);
    return m[idx];
  endfunction

  function automatic bit is_sema(int idx);
    return idx >= 3 && ((idx - 3) % 4) == 1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [11:0] a, logic [31:0] d, logic [NCH-1:0] done = '0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; eng_done = done;
    @(negedge clk);
    bus_wr = 1'b0; eng_done = '0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic eng_pulse(logic [NCH-1:0] done, logic [NCH-1:0] err, logic [8*NCH-1:0] code);
    @(negedge clk);
    eng_done = done; eng_err = err; eng_err_code = code;
    @(negedge clk);
    eng_done = '0; eng_err = '0; eng_err_code = '0;
    for (int c = 0; c < NCH; c++) begin
      if (done[c]) begin
        m[1][c] = 1'b1;
        if (m[4 + 4*c] != 0) m[4 + 4*c] = m[4 + 4*c] - 1;
      end
      if (err[c]) m[5 + 4*c] = m[5 + 4*c] | 32'(code[8*c +: 8]);
    end
  endtask

  task automatic check_outputs(string tag);
    logic [NCH-1:0] exp_irq_v;
    exp_irq_v = m[1][NCH-1:0] & m[0][NCH-1:0];
    check({tag, " R6 irq"}, 32'(irq), 32'(|exp_irq_v));
    check({tag, " R7 enable"}, 32'(chan_enable), 32'(m[2][NCH-1:0]));
    check({tag, " R7 prio"}, 32'(chan_high_prio), 32'(m[2][11:8]));
  endtask

  initial begin
    logic [31:0] rd, nv, d;
    int idx, op;
    logic [NCH-1:0] ek;
    void'($urandom(32'd2024));
    foreach (m[i]) m[i] = '0;
    m[0] = 32'h4000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    bus_read(12'h000, rd); check("R1 ctrl", rd, 32'h7000_0000);
    bus_read(12'h010, rd); check("R1 stat", rd, 32'h0);
    bus_read(12'h1F0, rd); check("R1 opt3", rd, 32'h0);
    check("R1 clock_gate", 32'(clock_gate), 32'h1);
    check("R1 outputs", 32'({soft_reset, irq, chan_kick, chan_enable}), 32'h0);
    check("R1 ptr", chan_ptr[31:0] | chan_ptr[127:96], 32'h0);

    // R2 R3 R6 R7 R9: random aliased traffic
    for (int it = 0; it < 600; it++) begin
      if (it % 16 == 0) begin
        eng_ready = 4'($urandom); eng_cur = 4'($urandom);
      end
      idx = $urandom_range(0, 18);
      op  = $urandom_range(0, 3);
      d   = $urandom;
      if (it % 5 == 0) d = 32'hFFFF_FFFF;
      if (idx == 0) d[31] = 1'b0;
      nv = next_val(op, m[idx], d, keep_of(idx));
      ek = '0;
      if (is_sema(idx) && nv[7:0] != 8'h0) ek[(idx - 3) / 4] = 1'b1;
      bus_write(addr_of(idx, op), d);
      check("R9 kick", 32'(chan_kick), 32'(ek));
      m[idx] = nv;
      idx = $urandom_range(0, 18);
      bus_read(addr_of(idx, $urandom_range(0, 3)), rd);
      check("R2 R3 readback", rd, exp_read(idx));
      check_outputs("rand");
    end
    for (int i = 0; i < 19; i++) begin
      bus_read(addr_of(i, i % 4), rd);
      check("R2 sweep", rd, exp_read(i));
    end
    for (int c = 0; c < NCH; c++) begin
      check("R8 ptr", chan_ptr[32*c +: 32], m[3 + 4*c]);
      check("R8 opt", chan_opt[32*c +: 32], m[6 + 4*c]);
    end

    // R3: unmapped and misaligned addresses
    bus_read(12'h030, rd); check("R3 unmapped 030", rd, 32'h0);
    bus_read(12'h0F0, rd); check("R3 unmapped 0F0", rd, 32'h0);
    bus_read(12'h200, rd); check("R3 unmapped 200", rd, 32'h0);
    bus_read(12'h102, rd); check("R3 misaligned 102", rd, 32'h0);

    // R4: capability and unused bits are fixed
    bus_write(12'h000, 32'h7FFF_FFFF); m[0] = 32'h4000_000F;
    bus_read(12'h000, rd); check("R4 ctrl all ones", rd, 32'h7000_000F);
    bus_write(12'h008, 32'h3000_0000);
    bus_read(12'h00C, rd); check("R4 caps after clear", rd, 32'h7000_000F);

    // R11: soft reset holds the other registers
    bus_write(12'h004, 32'h8000_0000);
    @(negedge clk);
    check("R11 soft_reset out", 32'(soft_reset), 32'h1);
    bus_read(12'h100, rd); check("R11 ptr0 cleared", rd, 32'h0);
    bus_write(12'h1C0, 32'h1234_5678);
    bus_read(12'h1C0, rd); check("R11 write ignored", rd, 32'h0);
    bus_write(12'h110, 32'h5);
    check("R11 no kick", 32'(chan_kick), 32'h0);
    eng_pulse(4'hF, 4'hF, 32'hFFFF_FFFF);
    bus_read(12'h010, rd); check("R11 done ignored", 32'(rd[3:0]), 32'h0);
    bus_read(12'h120, rd); check("R11 err ignored", rd, 32'h0);
    bus_write(12'h008, 32'h8000_0000);
    for (int i = 1; i < 19; i++) m[i] = '0;
    bus_read(12'h000, rd); check("R11 released ctrl", rd, 32'h7000_000F);
    check("R11 irq low", 32'(irq), 32'h0);

    // R5 R6: completion flags, priority over clear
    eng_ready = 4'hA; eng_cur = 4'h2;
    eng_pulse(4'b0101, 4'b0, '0);
    bus_read(12'h014, rd); check("R5 flags ready cur", rd, 32'h020A_0005);
    check("R6 irq on", 32'(irq), 32'h1);
    bus_write(12'h008, 32'h0000_000A); m[0] = 32'h4000_0005;
    bus_write(12'h018, 32'h0000_000F, 4'b0010); m[1] = 32'h2;
    bus_read(12'h010, rd); check("R5 done beats clear", 32'(rd[3:0]), 32'h2);
    check("R6 irq masked", 32'(irq), 32'h0);
    bus_write(12'h004, 32'h0000_0002); m[0] = 32'h4000_0007;
    check("R6 irq enabled", 32'(irq), 32'h1);

    // R9: semaphore start pulse and decrement
    bus_write(12'h150, 32'h3);
    check("R9 kick ch1", 32'(chan_kick), 32'h2);
    @(negedge clk);
    check("R9 kick one cycle", 32'(chan_kick), 32'h0);
    m[8] = 32'h3;
    eng_pulse(4'b0010, 4'b0, '0);
    bus_read(12'h150, rd); check("R9 decrement", rd, 32'h2);
    bus_write(12'h158, 32'h2);
    check("R9 zero result no kick", 32'(chan_kick), 32'h0);
    bus_write(12'h19C, 32'h1);
    check("R9 toggle kick ch2", 32'(chan_kick), 32'h4);

    // R10: error codes merge and stick
    eng_pulse(4'b1000, 4'b1000, 32'h2100_0000);
    eng_pulse(4'b0, 4'b1000, 32'h4400_0000);
    bus_read(12'h1E0, rd); check("R10 merged code", rd, 32'h65);
    bus_write(12'h1E8, 32'h21);
    bus_read(12'h1E4, rd); check("R10 sw clear", rd, 32'h44);

    // R7 R8: outputs after directed writes
    bus_write(12'h020, 32'hFFFF_FFFF); m[2] = 32'h0F0F;
    bus_write(12'h02C, 32'h0000_0501); m[2] = 32'h0A0E;
    check_outputs("dir");
    bus_write(12'h1C0, 32'hCAFE_0001);
    check("R8 ptr ch3", chan_ptr[127:96], 32'hCAFE_0001);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule